// File: doc/BRIEF.md
# Programmable-Tick Asynchronous Memory Strobe Sequencer

This block runs one asynchronous read or write access on an external parallel memory. A one-cycle start request, with a flag that picks read or write, launches the access. From then on a tick counter runs on the functional clock, starting at zero. Each control strobe (chip select, address valid, output enable, write enable) goes active at its own programmed tick and goes inactive at its own programmed tick. There is no fixed setup/hold state machine. Chip select and address valid each have separate inactive ticks for reads and for writes.

On a read, the block samples the memory data bus at a programmed access tick. On a write, it drives the write data onto the bus inside a programmed window. The total access length is set by a read-cycle count or a write-cycle count. A one-cycle done pulse marks the last tick, and the block goes idle on the following clock.

All timing fields are sampled when an access starts and are held for the whole access. A build-time capability switch moves the write-data window onto two extra fields: a data-mux start tick and a write-access end tick.

Top module: `amts_seq`

## Requirements
- R1: Out of reset and whenever idle, all strobes (`cs_n_o`, `adv_n_o`, `oe_n_o`, `we_n_o`) are high, and `wr_bus_en_o`, `done_o` and `busy_o` are low. `rd_data_o` resets to 0.
- R2: A `start_i` seen high at a clock edge while idle begins an access. In the next cycle `busy_o` is high and the access is at tick 0. Each later cycle advances the tick by one.
- R3: `cs_n_o` is low on every tick t with on ≤ t < off. The on time is the 4-bit `cs_on_i`. The off time is the 5-bit `cs_rd_off_i` for reads and the 5-bit `cs_wr_off_i` for writes. A value of 0 means tick 0, and an off time ≤ the on time never asserts the strobe.
- R4: `adv_n_o` follows the same window rule. Its on time is `adv_on_i`, and its off time is `adv_rd_off_i` on reads and `adv_wr_off_i` on writes.
- R5: On reads, `oe_n_o` is low for on ≤ t < off, using `oe_on_i`/`oe_off_i`, and `we_n_o` stays high. On writes, `we_n_o` is low for on ≤ t < off, using `we_on_i`/`we_off_i`, and `oe_n_o` stays high.
- R6: The access lasts L+1 ticks. L is `rd_cycle_i` for reads and `wr_cycle_i` for writes. `done_o` is high only on tick L, and on the next cycle the block is idle.
- R7: On a read, `rd_data_o` takes the value of `rd_bus_i` present during tick `access_i`, one clock after that tick. If `access_i` > L, or the access is a write, `rd_data_o` keeps its old value.
- R8: With the capability off, a write drives `wr_bus_en_o` high and `wr_bus_o` = the write data for `we_on_i` ≤ t < `cs_wr_off_i`. Otherwise `wr_bus_en_o` is low and `wr_bus_o` is 0.
- R9: With the capability on, the write-data window becomes `wr_mux_i` ≤ t < `wr_access_i`.
- R10: A `start_i` pulse while an access is in progress is ignored. The running access keeps its tick sequence and length.
- R11: Timing fields, the read/write flag and the write data are sampled at the start edge. Changes to them during an access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access request, sampled while idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| cs_on_i | input | 4 | Chip-select active tick |
| cs_rd_off_i | input | 5 | Chip-select inactive tick, reads |
| cs_wr_off_i | input | 5 | Chip-select inactive tick, writes |
| adv_on_i | input | 4 | Address-valid active tick |
| adv_rd_off_i | input | 5 | Address-valid inactive tick, reads |
| adv_wr_off_i | input | 5 | Address-valid inactive tick, writes |
| oe_on_i | input | 4 | Output-enable active tick |
| oe_off_i | input | 5 | Output-enable inactive tick |
| we_on_i | input | 4 | Write-enable active tick |
| we_off_i | input | 5 | Write-enable inactive tick |
| rd_cycle_i | input | 5 | Last tick of a read |
| wr_cycle_i | input | 5 | Last tick of a write |
| access_i | input | 5 | Read sampling tick |
| wr_access_i | input | 5 | End of write-data window (capability on) |
| wr_mux_i | input | 4 | Start of write-data window (capability on) |
| wr_data_i | input | 16 | Write data |
| rd_bus_i | input | 16 | Memory data bus, read direction |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| wr_bus_o | output | 16 | Write data toward the memory bus |
| wr_bus_en_o | output | 1 | Write data bus drive enable |
| rd_data_o | output | 16 | Captured read data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Last tick of the access |

## Verification
The assertions assume that `start_i` is only meaningful on clock edges and that the timing inputs are stable at the start edge. They place no ordering requirement among the fields: an off time earlier than its on time, or a sampling tick past the end of the access, is legal and simply yields an unasserted strobe or no capture. The stimulus covers exactly these cases: zero fields, all-ones fields, inverted windows and a late sampling tick. It changes fields and pulses `start_i` only while an access runs, so that both holds are exercised without breaking the start-edge assumption.

// File: rtl/amts_pkg.sv
package amts_pkg;

    localparam int TK_W   = 5;   // long tick fields and the tick counter
    localparam int ON_W   = 4;   // short tick fields
    localparam int NUM_SB = 5;   // strobe windows

    localparam int SB_CS  = 0;
    localparam int SB_ADV = 1;
    localparam int SB_OE  = 2;
    localparam int SB_WE  = 3;
    localparam int SB_DAT = 4;

    typedef logic [TK_W-1:0] tick_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } amts_state_e;

    typedef struct packed {
        logic [ON_W-1:0] cs_on;
        tick_t           cs_rd_off;
        tick_t           cs_wr_off;
        logic [ON_W-1:0] adv_on;
        tick_t           adv_rd_off;
        tick_t           adv_wr_off;
        logic [ON_W-1:0] oe_on;
        tick_t           oe_off;
        logic [ON_W-1:0] we_on;
        tick_t           we_off;
        tick_t           rd_cycle;
        tick_t           wr_cycle;
        tick_t           access;
        tick_t           wr_access;
        logic [ON_W-1:0] wr_mux;
    } amts_cfg_t;

    function automatic tick_t widen(input logic [ON_W-1:0] v);
        return tick_t'(v);
    endfunction

    function automatic tick_t last_tick(input amts_cfg_t c, input logic wr);
        return wr ? c.wr_cycle : c.rd_cycle;
    endfunction

endpackage

// File: rtl/amts_tick_counter.sv
module amts_tick_counter
    import amts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  tick_t last_i,
    output logic  accept_o,
    output logic  busy_o,
    output logic  done_o,
    output tick_t tick_o
);
    amts_state_e state_q;
    tick_t       tick_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign busy_o   = (state_q == ST_RUN);
    assign done_o   = busy_o && (tick_q == last_i);
    assign tick_o   = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tick_q <= '0;
                    if (start_i) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (tick_q == last_i) begin
                        state_q <= ST_IDLE;
                        tick_q  <= '0;
                    end else begin
                        tick_q <= tick_q + tick_t'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/amts_cfg_hold.sv
module amts_cfg_hold
    import amts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  amts_cfg_t         cfg_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output amts_cfg_t         cfg_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o   <= '0;
            wr_o    <= 1'b0;
            wdata_o <= '0;
        end else if (accept_i) begin
            cfg_o   <= cfg_i;
            wr_o    <= wr_i;
            wdata_o <= wdata_i;
        end
    end
endmodule

// File: rtl/amts_strobe_window.sv
module amts_strobe_window
    import amts_pkg::*;
(
    input  logic  en_i,
    input  tick_t tick_i,
    input  tick_t on_i,
    input  tick_t off_i,
    output logic  active_o
);
    assign active_o = en_i && (tick_i >= on_i) && (tick_i < off_i);
endmodule

// File: rtl/amts_read_capture.sv
module amts_read_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst)           data_o <= '0;
        else if (sample_i) data_o <= bus_i;
    end
endmodule

// File: rtl/amts_seq.sv
module amts_seq
    import amts_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit HAS_WR_EXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [3:0]        cs_on_i,
    input  logic [4:0]        cs_rd_off_i,
    input  logic [4:0]        cs_wr_off_i,
    input  logic [3:0]        adv_on_i,
    input  logic [4:0]        adv_rd_off_i,
    input  logic [4:0]        adv_wr_off_i,
    input  logic [3:0]        oe_on_i,
    input  logic [4:0]        oe_off_i,
    input  logic [3:0]        we_on_i,
    input  logic [4:0]        we_off_i,
    input  logic [4:0]        rd_cycle_i,
    input  logic [4:0]        wr_cycle_i,
    input  logic [4:0]        access_i,
    input  logic [4:0]        wr_access_i,
    input  logic [3:0]        wr_mux_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] rd_bus_i,
    output logic              cs_n_o,
    output logic              adv_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [DATA_W-1:0] wr_bus_o,
    output logic              wr_bus_en_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o
);
    amts_cfg_t         cfg_in, cfg_q;
    logic              wr_q, accept, busy;
    logic [DATA_W-1:0] wdata_q;
    tick_t             tick;
    tick_t             on_v   [NUM_SB];
    tick_t             off_v  [NUM_SB];
    logic              en_v   [NUM_SB];
    logic              act_v  [NUM_SB];

    always_comb begin
        cfg_in.cs_on      = cs_on_i;
        cfg_in.cs_rd_off  = cs_rd_off_i;
        cfg_in.cs_wr_off  = cs_wr_off_i;
        cfg_in.adv_on     = adv_on_i;
        cfg_in.adv_rd_off = adv_rd_off_i;
        cfg_in.adv_wr_off = adv_wr_off_i;
        cfg_in.oe_on      = oe_on_i;
        cfg_in.oe_off     = oe_off_i;
        cfg_in.we_on      = we_on_i;
        cfg_in.we_off     = we_off_i;
        cfg_in.rd_cycle   = rd_cycle_i;
        cfg_in.wr_cycle   = wr_cycle_i;
        cfg_in.access     = access_i;
        cfg_in.wr_access  = wr_access_i;
        cfg_in.wr_mux     = wr_mux_i;
    end

    amts_cfg_hold #(.DATA_W(DATA_W)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .cfg_i    (cfg_in),
        .wr_i     (write_i),
        .wdata_i  (wr_data_i),
        .cfg_o    (cfg_q),
        .wr_o     (wr_q),
        .wdata_o  (wdata_q)
    );

    amts_tick_counter cnt_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .last_i   (last_tick(cfg_q, wr_q)),
        .accept_o (accept),
        .busy_o   (busy),
        .done_o   (done_o),
        .tick_o   (tick)
    );

    // window selection per strobe
    always_comb begin
        on_v[SB_CS]   = widen(cfg_q.cs_on);
        off_v[SB_CS]  = wr_q ? cfg_q.cs_wr_off : cfg_q.cs_rd_off;
        en_v[SB_CS]   = busy;
        on_v[SB_ADV]  = widen(cfg_q.adv_on);
        off_v[SB_ADV] = wr_q ? cfg_q.adv_wr_off : cfg_q.adv_rd_off;
        en_v[SB_ADV]  = busy;
        on_v[SB_OE]   = widen(cfg_q.oe_on);
        off_v[SB_OE]  = cfg_q.oe_off;
        en_v[SB_OE]   = busy && !wr_q;
        on_v[SB_WE]   = widen(cfg_q.we_on);
        off_v[SB_WE]  = cfg_q.we_off;
        en_v[SB_WE]   = busy && wr_q;
        en_v[SB_DAT]  = busy && wr_q;
    end

    generate
        if (HAS_WR_EXT) begin : g_dat_ext
            always_comb begin
                on_v[SB_DAT]  = widen(cfg_q.wr_mux);
                off_v[SB_DAT] = cfg_q.wr_access;
            end
        end else begin : g_dat_base
            always_comb begin
                on_v[SB_DAT]  = widen(cfg_q.we_on);
                off_v[SB_DAT] = cfg_q.cs_wr_off;
            end
        end
    endgenerate

    generate
        for (genvar k = 0; k < NUM_SB; k++) begin : g_win
            amts_strobe_window win_i (
                .en_i     (en_v[k]),
                .tick_i   (tick),
                .on_i     (on_v[k]),
                .off_i    (off_v[k]),
                .active_o (act_v[k])
            );
        end
    endgenerate

    amts_read_capture #(.DATA_W(DATA_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .sample_i (busy && !wr_q && (tick == cfg_q.access)),
        .bus_i    (rd_bus_i),
        .data_o   (rd_data_o)
    );

    assign cs_n_o      = !act_v[SB_CS];
    assign adv_n_o     = !act_v[SB_ADV];
    assign oe_n_o      = !act_v[SB_OE];
    assign we_n_o      = !act_v[SB_WE];
    assign wr_bus_en_o = act_v[SB_DAT];
    assign wr_bus_o    = act_v[SB_DAT] ? wdata_q : '0;
    assign busy_o      = busy;
endmodule

// File: rtl/amts_seq_chk.sv
module amts_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              cs_n_o,
    input logic              adv_n_o,
    input logic              oe_n_o,
    input logic              we_n_o,
    input logic              wr_bus_en_o,
    input logic [DATA_W-1:0] rd_data_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cs_n_o && adv_n_o && oe_n_o && we_n_o && !wr_bus_en_o && !done_o)); // R1

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o); // R2

    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n_o && !we_n_o)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R6

    AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(rd_data_o)); // R7

    AST_BUS_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        wr_bus_en_o |-> oe_n_o); // R8

    AST_RUN_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o); // R10
endmodule

bind amts_seq amts_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cs_n_o      (cs_n_o),
    .adv_n_o     (adv_n_o),
    .oe_n_o      (oe_n_o),
    .we_n_o      (we_n_o),
    .wr_bus_en_o (wr_bus_en_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/amts_seq_tb_top.sv
module amts_seq_tb_top;
    import amts_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic wr = 1'b0;
    amts_cfg_t cfg_drv = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_bus = 16'hFFFF;

    logic cs_n, adv_n, oe_n, we_n, bus_en, busy, done;
    logic [DW-1:0] wbus, rdata;
    logic cs_n_x, adv_n_x, oe_n_x, we_n_x, bus_en_x, busy_x, done_x;
    logic [DW-1:0] wbus_x, rdata_x;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int          t;
        logic        cs_n, adv_n, oe_n, we_n, en, en_x, done;
        logic [DW-1:0] dat, dat_x;
    } item_t;
    item_t q[$];
    logic [DW-1:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amts_seq #(.DATA_W(DW), .HAS_WR_EXT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .write_i(wr),
        .cs_on_i(cfg_drv.cs_on), .cs_rd_off_i(cfg_drv.cs_rd_off), .cs_wr_off_i(cfg_drv.cs_wr_off),
        .adv_on_i(cfg_drv.adv_on), .adv_rd_off_i(cfg_drv.adv_rd_off), .adv_wr_off_i(cfg_drv.adv_wr_off),
        .oe_on_i(cfg_drv.oe_on), .oe_off_i(cfg_drv.oe_off), .we_on_i(cfg_drv.we_on), .we_off_i(cfg_drv.we_off),
        .rd_cycle_i(cfg_drv.rd_cycle), .wr_cycle_i(cfg_drv.wr_cycle), .access_i(cfg_drv.access),
        .wr_access_i(cfg_drv.wr_access), .wr_mux_i(cfg_drv.wr_mux), .wr_data_i(wdata), .rd_bus_i(rd_bus),
        .cs_n_o(cs_n), .adv_n_o(adv_n), .oe_n_o(oe_n), .we_n_o(we_n), .wr_bus_o(wbus),
        .wr_bus_en_o(bus_en), .rd_data_o(rdata), .busy_o(busy), .done_o(done)
    );

    amts_seq #(.DATA_W(DW), .HAS_WR_EXT(1'b1)) dut_ext_i (
        .clk(clk), .rst(rst), .start_i(start), .write_i(wr),
        .cs_on_i(cfg_drv.cs_on), .cs_rd_off_i(cfg_drv.cs_rd_off), .cs_wr_off_i(cfg_drv.cs_wr_off),
        .adv_on_i(cfg_drv.adv_on), .adv_rd_off_i(cfg_drv.adv_rd_off), .adv_wr_off_i(cfg_drv.adv_wr_off),
        .oe_on_i(cfg_drv.oe_on), .oe_off_i(cfg_drv.oe_off), .we_on_i(cfg_drv.we_on), .we_off_i(cfg_drv.we_off),
        .rd_cycle_i(cfg_drv.rd_cycle), .wr_cycle_i(cfg_drv.wr_cycle), .access_i(cfg_drv.access),
        .wr_access_i(cfg_drv.wr_access), .wr_mux_i(cfg_drv.wr_mux), .wr_data_i(wdata), .rd_bus_i(rd_bus),
        .cs_n_o(cs_n_x), .adv_n_o(adv_n_x), .oe_n_o(oe_n_x), .we_n_o(we_n_x), .wr_bus_o(wbus_x),
        .wr_bus_en_o(bus_en_x), .rd_data_o(rdata_x), .busy_o(busy_x), .done_o(done_x)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
        end
    endtask

    function automatic logic win(input int t, input int on, input int off);
        return (t >= on) && (t < off);
    endfunction

    // monitor: one expected item per access tick
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            chk(busy === 1'b1,        "R2 busy",   {15'd0, busy},   16'd1);
            chk(cs_n === e.cs_n,      "R3 cs_n",   {15'd0, cs_n},   {15'd0, e.cs_n});
            chk(adv_n === e.adv_n,    "R4 adv_n",  {15'd0, adv_n},  {15'd0, e.adv_n});
            chk(oe_n === e.oe_n,      "R5 oe_n",   {15'd0, oe_n},   {15'd0, e.oe_n});
            chk(we_n === e.we_n,      "R5 we_n",   {15'd0, we_n},   {15'd0, e.we_n});
            chk(done === e.done,      "R6 done",   {15'd0, done},   {15'd0, e.done});
            chk(bus_en === e.en,      "R8 bus_en", {15'd0, bus_en}, {15'd0, e.en});
            chk(wbus === e.dat,       "R8 wbus",   wbus,            e.dat);
            chk(bus_en_x === e.en_x,  "R9 bus_en", {15'd0, bus_en_x}, {15'd0, e.en_x});
            chk(wbus_x === e.dat_x,   "R9 wbus",   wbus_x,          e.dat_x);
            chk(cs_n_x === e.cs_n,    "R3 cs_n ext", {15'd0, cs_n_x}, {15'd0, e.cs_n});
            rd_bus = 16'h5A00 | DW'(e.t);
        end
    end

    task automatic check_idle(input string tag);
        chk(busy === 1'b0 && busy_x === 1'b0, {tag, " busy"}, {15'd0, busy}, 16'd0);
        chk({cs_n, adv_n, oe_n, we_n} === 4'hF, {tag, " strobes"}, {12'd0, cs_n, adv_n, oe_n, we_n}, 16'h000F);
        chk(bus_en === 1'b0 && done === 1'b0, {tag, " en/done"}, {14'd0, bus_en, done}, 16'd0);
    endtask

    // driver: launch one access and push its expected tick stream
    task automatic run(input amts_cfg_t c, input logic w, input logic [DW-1:0] d, input bit disturb);
        int len;
        @(negedge clk);
        cfg_drv = c; wr = w; wdata = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        len = w ? int'(c.wr_cycle) : int'(c.rd_cycle);
        for (int t = 0; t <= len; t++) begin
            item_t e;
            int coff, aoff;
            coff = w ? int'(c.cs_wr_off) : int'(c.cs_rd_off);
            aoff = w ? int'(c.adv_wr_off) : int'(c.adv_rd_off);
            e.t     = t;
            e.cs_n  = !win(t, int'(c.cs_on), coff);
            e.adv_n = !win(t, int'(c.adv_on), aoff);
            e.oe_n  = !(!w && win(t, int'(c.oe_on), int'(c.oe_off)));
            e.we_n  = !(w && win(t, int'(c.we_on), int'(c.we_off)));
            e.en    = w && win(t, int'(c.we_on), int'(c.cs_wr_off));
            e.en_x  = w && win(t, int'(c.wr_mux), int'(c.wr_access));
            e.dat   = e.en ? d : '0;
            e.dat_x = e.en_x ? d : '0;
            e.done  = (t == len);
            q.push_back(e);
        end
        if (!w && int'(c.access) <= len) exp_rd = 16'h5A00 | DW'(c.access);
        if (disturb) begin
            // R10 and R11: new start and new fields mid-access
            @(negedge clk); @(negedge clk);
            cfg_drv = ~c; wr = ~w; wdata = ~d; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
        check_idle("R6 back to idle / R10 ignored start");
        chk(rdata === exp_rd, "R7 rd_data", rdata, exp_rd);
        rd_bus = 16'hFFFF;
    endtask

    initial begin
        amts_cfg_t c;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset");
        chk(rdata === '0, "R1 rd_data reset", rdata, '0);

        c = '0;
        c.cs_on = 4'd1; c.cs_rd_off = 5'd11; c.cs_wr_off = 5'd9;
        c.adv_on = 4'd1; c.adv_rd_off = 5'd3; c.adv_wr_off = 5'd4;
        c.oe_on = 4'd4; c.oe_off = 5'd10; c.we_on = 4'd3; c.we_off = 5'd7;
        c.rd_cycle = 5'd12; c.wr_cycle = 5'd10; c.access = 5'd9;
        c.wr_mux = 4'd2; c.wr_access = 5'd8;
        run(c, 1'b0, 16'h0000, 1'b0);           // typical read
        run(c, 1'b1, 16'hBEEF, 1'b0);           // typical write, R7 hold
        chk(rdata === 16'h5A09, "R7 write leaves rd_data", rdata, 16'h5A09);

        run('0, 1'b0, 16'h0, 1'b0);             // all zero: one tick, no strobes, capture at 0
        run('0, 1'b1, 16'h1234, 1'b0);

        c = '1;                                  // all ones: on 15, off 31, len 31
        run(c, 1'b0, 16'h0, 1'b0);
        run(c, 1'b1, 16'hA5A5, 1'b0);

        c = '0;                                  // inverted windows, access past end
        c.cs_on = 4'd9; c.cs_rd_off = 5'd3; c.cs_wr_off = 5'd2;
        c.adv_on = 4'd0; c.adv_rd_off = 5'd6; c.adv_wr_off = 5'd1;
        c.oe_on = 4'd0; c.oe_off = 5'd5; c.we_on = 4'd0; c.we_off = 5'd5;
        c.rd_cycle = 5'd6; c.wr_cycle = 5'd6; c.access = 5'd20;
        c.wr_mux = 4'd5; c.wr_access = 5'd3;
        run(c, 1'b0, 16'h0, 1'b0);
        run(c, 1'b1, 16'h7777, 1'b0);

        c.access = 5'd4; c.cs_on = 4'd2; c.cs_rd_off = 5'd8; c.cs_wr_off = 5'd8;
        c.rd_cycle = 5'd9; c.wr_cycle = 5'd9; c.wr_mux = 4'd1; c.wr_access = 5'd7;
        run(c, 1'b0, 16'h0, 1'b1);              // R10/R11 disturbance on read
        run(c, 1'b1, 16'h0F0F, 1'b1);           // and on write
        chk(rdata_x === rdata, "R7 variants agree", rdata_x, rdata);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule